// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks a predivider and feedback divider for a clock synthesiser. It takes a reference frequency and a requested lane rate, both whole MHz. It tries every allowed predivider in turn and keeps the pair whose synthesised frequency comes closest to the target. The target is twice the lane rate. A single start pulse launches a search. The block drops busy and pulses done when the search is over. It then holds the chosen dividers, the lane rate that pair achieves, and a flag that says whether any candidate was usable.

All arithmetic goes through one shared sequential divider. Each divide takes one cycle per dividend bit. The range bounds take two divides at the beginning. After that, each predivider costs one divide for the feedback value and, when that value passes the screen, a second divide for the achieved frequency. The block trades search time for a small amount of logic, which suits a setup step that runs seldom.

Top module: `pll_div_search`

## Requirements
- R1: The target frequency is twice `rate_mhz`, limited to a ceiling of 5000.
- R2: The predividers tried run from ceil(fin/40) to floor(fin/5) inclusive, and zero is never tried. When that range is empty, no candidate exists.
- R3: For predivider p, the feedback divider is floor(target × p / fin).
- R4: A feedback divider is rejected when it is smaller than 12, larger than 511, or exactly 15.
- R5: An accepted pair yields floor(fb × fin / p). Its error is the absolute difference from the target. A candidate replaces the kept pair only when its error is strictly smaller, so on a tie the smaller predivider wins.
- R6: `lane_rate` is floor(best achieved frequency / 2).
- R7: When no candidate is accepted, `prediv` and `fbdiv` read 1 and `lane_rate` reads 0.
- R8: `found` is high after a search only if at least one candidate was accepted.
- R9: `done` is high for exactly one cycle at the end of a search. `busy` is high from the cycle after the start until that pulse. The results hold until the next accepted start.
- R10: A start that arrives while `busy` is high is ignored. Its operands do not affect the result.
- R11: After reset: `busy`, `done` and `found` are 0, `prediv` and `fbdiv` are 1, and `lane_rate` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a search when idle |
| fin_mhz | input | 12 | Reference frequency, MHz |
| rate_mhz | input | 12 | Requested lane rate, MHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | At least one candidate was accepted |
| prediv | output | 10 | Chosen predivider |
| fbdiv | output | 9 | Chosen feedback divider |
| lane_rate | output | 14 | Lane rate achieved by the chosen pair, MHz |

## Verification
A search takes a number of cycles that depends on the data: 23 cycles per divide, two divides for the bounds, and one or two divides per predivider. The bench therefore does not count cycles. After each start it steps on falling edges until it sees `done`, and it reads all four results in that same half cycle. One falling edge later it checks that `done` has dropped and `busy` is low. Expected values come from a bench model that scans the same predivider range in ordinary integer arithmetic. A second start issued mid-search must leave the first search's results unchanged.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LO,
        ST_HI,
        ST_FB,
        ST_ACH
    } search_state_e;
endpackage

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
    parameter int W = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic             active;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     rem;
        logic [W-1:0]     quo;
        logic [W-1:0]     den;
        logic [W-1:0]     num;
    } div_state_t;

    div_state_t q, n;
    logic [W:0] trial;

    always_comb begin
        n     = q;
        n.done = 1'b0;
        trial = {q.rem, q.quo[W-1]};
        if (go) begin
            n.active = 1'b1;
            n.cnt    = CNT_W'(W);
            n.rem    = '0;
            n.quo    = num;
            n.den    = den;
            n.num    = num;
        end else if (q.active) begin
            if (trial >= {1'b0, q.den}) begin
                n.rem = W'(trial - {1'b0, q.den});
                n.quo = {q.quo[W-2:0], 1'b1};
            end else begin
                n.rem = trial[W-1:0];
                n.quo = {q.quo[W-2:0], 1'b0};
            end
            n.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                n.active = 1'b0;
                n.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign done = q.done;
    assign quo  = q.quo;

    // R3
    quotient_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.den != '0) |->
            (({{W{1'b0}}, q.quo} * {{W{1'b0}}, q.den} <= {{W{1'b0}}, q.num}) &&
             ({{W{1'b0}}, q.quo} * {{W{1'b0}}, q.den} + {{W{1'b0}}, q.den} > {{W{1'b0}}, q.num})));
endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval #(
    parameter int PROD_W  = 23,
    parameter int ACH_W   = 15,
    parameter int FB_MIN  = 12,
    parameter int FB_MAX  = 511,
    parameter int FB_HOLE = 15
) (
    input  logic [PROD_W-1:0] fb_raw,
    input  logic [ACH_W-1:0]  ach,
    input  logic [ACH_W-1:0]  target,
    output logic              fb_ok,
    output logic [ACH_W-1:0]  err
);
    always_comb begin
        fb_ok = (fb_raw >= PROD_W'(FB_MIN)) && (fb_raw <= PROD_W'(FB_MAX))
             && (fb_raw != PROD_W'(FB_HOLE));
        err   = (ach >= target) ? (ach - target) : (target - ach);
    end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pll_search_pkg::*;
#(
    parameter int FIN_W    = 12,
    parameter int RATE_W   = 12,
    parameter int PDIV_W   = 10,
    parameter int FBDIV_W  = 9,
    parameter int MAX_LANE = 2500,
    parameter int IF_MIN   = 5,
    parameter int IF_MAX   = 40,
    parameter int FB_MIN   = 12,
    parameter int FB_MAX   = 511,
    parameter int FB_HOLE  = 15,
    localparam int ACH_W   = FBDIV_W + $clog2(IF_MAX + 1),
    localparam int OUT_W   = ACH_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FIN_W-1:0]  fin_mhz,
    input  logic [RATE_W-1:0] rate_mhz,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic [PDIV_W-1:0] prediv,
    output logic [FBDIV_W-1:0] fbdiv,
    output logic [OUT_W-1:0]  lane_rate
);
    localparam int FOUT_W  = RATE_W + 1;
    localparam int PROD_A  = FOUT_W + PDIV_W;
    localparam int PROD_B  = FBDIV_W + FIN_W;
    localparam int PROD_W  = (PROD_A > PROD_B) ? PROD_A : PROD_B;
    localparam int FOUT_CAP = 2 * MAX_LANE;

    typedef struct packed {
        search_state_e      st;
        logic [FIN_W-1:0]   fin;
        logic [FOUT_W-1:0]  fout;
        logic [PDIV_W-1:0]  p;
        logic [PDIV_W-1:0]  hi;
        logic [FBDIV_W-1:0] fb;
        logic [PDIV_W-1:0]  best_p;
        logic [FBDIV_W-1:0] best_fb;
        logic [ACH_W-1:0]   best_ach;
        logic [ACH_W-1:0]   best_err;
        logic               found;
        logic               done;
    } search_t;

    search_t q, n;

    logic              div_go, div_done;
    logic [PROD_W-1:0] div_num, div_den, div_quo;
    logic              fb_ok;
    logic [ACH_W-1:0]  cand_err;
    logic              step;
    logic [FOUT_W-1:0] fout_req;

    pll_seq_div #(.W(PROD_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (div_num),
        .den  (div_den),
        .done (div_done),
        .quo  (div_quo)
    );

    pll_cand_eval #(
        .PROD_W (PROD_W),
        .ACH_W  (ACH_W),
        .FB_MIN (FB_MIN),
        .FB_MAX (FB_MAX),
        .FB_HOLE(FB_HOLE)
    ) u_eval (
        .fb_raw(div_quo),
        .ach   (div_quo[ACH_W-1:0]),
        .target(ACH_W'(q.fout)),
        .fb_ok (fb_ok),
        .err   (cand_err)
    );

    always_comb begin
        n        = q;
        n.done   = 1'b0;
        div_go   = 1'b0;
        div_num  = '0;
        div_den  = '0;
        step     = 1'b0;
        fout_req = {rate_mhz, 1'b0};
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    n.fin      = fin_mhz;
                    n.fout     = (fout_req > FOUT_W'(FOUT_CAP)) ? FOUT_W'(FOUT_CAP) : fout_req;
                    n.best_p   = PDIV_W'(1);
                    n.best_fb  = FBDIV_W'(1);
                    n.best_ach = '0;
                    n.best_err = '1;
                    n.found    = 1'b0;
                    div_go     = 1'b1;
                    div_num    = PROD_W'(fin_mhz) + PROD_W'(IF_MAX - 1);
                    div_den    = PROD_W'(IF_MAX);
                    n.st       = ST_LO;
                end
            end
            ST_LO: begin
                if (div_done) begin
                    n.p     = (div_quo == '0) ? PDIV_W'(1) : div_quo[PDIV_W-1:0];
                    div_go  = 1'b1;
                    div_num = PROD_W'(q.fin);
                    div_den = PROD_W'(IF_MIN);
                    n.st    = ST_HI;
                end
            end
            ST_HI: begin
                if (div_done) begin
                    n.hi = div_quo[PDIV_W-1:0];
                    if (PROD_W'(q.p) > div_quo) begin
                        n.st   = ST_IDLE;
                        n.done = 1'b1;
                    end else begin
                        div_go  = 1'b1;
                        div_num = PROD_W'(q.fout) * PROD_W'(q.p);
                        div_den = PROD_W'(q.fin);
                        n.st    = ST_FB;
                    end
                end
            end
            ST_FB: begin
                if (div_done) begin
                    if (fb_ok) begin
                        n.fb    = div_quo[FBDIV_W-1:0];
                        div_go  = 1'b1;
                        div_num = PROD_W'(div_quo[FBDIV_W-1:0]) * PROD_W'(q.fin);
                        div_den = PROD_W'(q.p);
                        n.st    = ST_ACH;
                    end else begin
                        step = 1'b1;
                    end
                end
            end
            ST_ACH: begin
                if (div_done) begin
                    if (cand_err < q.best_err) begin
                        n.best_err = cand_err;
                        n.best_ach = div_quo[ACH_W-1:0];
                        n.best_p   = q.p;
                        n.best_fb  = q.fb;
                        n.found    = 1'b1;
                    end
                    step = 1'b1;
                end
            end
            default: n.st = ST_IDLE;
        endcase
        if (step) begin
            if (q.p == q.hi) begin
                n.st   = ST_IDLE;
                n.done = 1'b1;
            end else begin
                n.p     = q.p + 1'b1;
                div_go  = 1'b1;
                div_num = PROD_W'(q.fout) * PROD_W'(q.p + 1'b1);
                div_den = PROD_W'(q.fin);
                n.st    = ST_FB;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_IDLE;
            q.best_p  <= PDIV_W'(1);
            q.best_fb <= FBDIV_W'(1);
        end else begin
            q <= n;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign found     = q.found;
    assign prediv    = q.best_p;
    assign fbdiv     = q.best_fb;
    assign lane_rate = q.best_ach[ACH_W-1:1];

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(q.fin) && $stable(q.fout)));
    // R7
    no_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (prediv == PDIV_W'(1) && fbdiv == FBDIV_W'(1) && lane_rate == '0));
    // R4
    fb_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (fbdiv >= FBDIV_W'(FB_MIN) && fbdiv <= FBDIV_W'(FB_MAX)
                             && fbdiv != FBDIV_W'(FB_HOLE)));
    // R2
    prediv_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FB) |-> (q.p != '0));
    // R1
    target_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q.fout <= FOUT_W'(FOUT_CAP)));
endmodule

// File: tb/pll_div_search_test.sv
`timescale 1ns/1ps
module pll_div_search_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] fin_mhz = '0;
    logic [11:0] rate_mhz = '0;
    logic        busy, done, found;
    logic [9:0]  prediv;
    logic [8:0]  fbdiv;
    logic [13:0] lane_rate;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    pll_div_search uut (
        .clk(clk), .rst_n(rst_n), .start(start), .fin_mhz(fin_mhz),
        .rate_mhz(rate_mhz), .busy(busy), .done(done), .found(found),
        .prediv(prediv), .fbdiv(fbdiv), .lane_rate(lane_rate)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ref_model(input int fin, input int rate,
                             output int ep, output int efb, output int erate, output int efound);
        int fout, lo, hi, best_err;
        fout = 2 * rate;
        if (fout > 5000) fout = 5000;
        lo = (fin + 39) / 40;
        if (lo == 0) lo = 1;
        hi = fin / 5;
        ep = 1; efb = 1; erate = 0; efound = 0;
        best_err = 32'h7fffffff;
        for (int p = lo; p <= hi; p++) begin
            int fb, ach, err;
            fb = (fout * p) / fin;
            if (fb < 12 || fb > 511 || fb == 15) continue;
            ach = (fb * fin) / p;
            err = (ach > fout) ? ach - fout : fout - ach;
            if (err < best_err) begin
                best_err = err; ep = p; efb = fb; erate = ach / 2; efound = 1;
            end
        end
    endtask

    task automatic pulse_start(input int fin, input int rate);
        @(negedge clk);
        fin_mhz  = 12'(fin);
        rate_mhz = 12'(rate);
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 60000) begin
            @(negedge clk);
            guard++;
        end
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL R9 actual=no_done expected=done");
        end
    endtask

    task automatic finish_and_check(input string tag, input int fin, input int rate);
        int ep, efb, erate, efound;
        ref_model(fin, rate, ep, efb, erate, efound);
        wait_done();
        check({tag, " R5 prediv"}, int'(prediv), ep);
        check({tag, " R3 R4 fbdiv"}, int'(fbdiv), efb);
        check({tag, " R6 lane_rate"}, int'(lane_rate), erate);
        check({tag, " R8 found"}, int'(found), efound);
        @(negedge clk);
        check({tag, " R9 done dropped"}, int'(done), 0);
        check({tag, " R9 idle"}, int'(busy), 0);
    endtask

    task automatic run(input string tag, input int fin, input int rate);
        pulse_start(fin, rate);
        check({tag, " R9 busy"}, int'(busy), 1);
        finish_and_check(tag, fin, rate);
    endtask

    initial begin
        #150000;
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        int ep, efb, erate, efound;
        void'($urandom(32'd7719));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 busy", int'(busy), 0);
        check("R11 done", int'(done), 0);
        check("R11 found", int'(found), 0);
        check("R11 prediv", int'(prediv), 1);
        check("R11 fbdiv", int'(fbdiv), 1);
        check("R11 lane_rate", int'(lane_rate), 0);

        run("typical", 24, 1000);
        run("R1 cap", 24, 3000);
        ref_model(24, 3000, ep, efb, erate, efound);
        check("R1 capped rate", int'(lane_rate), erate);
        // R2 empty range, R7 defaults
        run("R2 R7 empty", 4, 800);
        check("R7 prediv default", int'(prediv), 1);
        check("R7 lane_rate zero", int'(lane_rate), 0);
        // R4 every feedback value too small
        run("R4 R7 low", 24, 5);
        run("R2 fin0", 0, 500);
        run("R5 tie", 50, 300);
        run("hole", 40, 150);

        // R10: second start mid-search is ignored
        pulse_start(24, 1200);
        repeat (20) @(negedge clk);
        fin_mhz = 12'd97; rate_mhz = 12'd333; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_and_check("R10 ignored", 24, 1200);

        for (int i = 0; i < 20; i++) begin
            int f, r;
            f = int'($urandom_range(160, 5));
            r = int'($urandom_range(2800, 0));
            run("random", f, r);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule